// File: doc/BRIEF.md
# Shadowed DAC Setting Registers

This block holds two analog settings for a laser bias and modulation controller: a 10-bit reference setting and an 8-bit current setting. Each setting has a working copy that drives its converter continuously and a retained copy that survives a power-up reset. A byte-level transaction port gives access to both copies. A host opens a transaction by presenting a word address, then writes or reads bytes, and closes the transaction with an end strobe. The serial framing in front of this port lies outside the block.

The retained copies can be reached only through the working copies. Reading a retained address first loads the working copy from it, so the converter input moves at that moment. Writing a retained address stages the bytes, updates the working copy when the transaction ends, and then runs a timed commit into the retained copy. While the commit runs, the block shows busy and refuses every request with a not-ready pulse. At power-up, two configuration bits choose, one per setting, whether the working copy starts at zero or from the retained copy.

Top module: `dac_shadow_regs`

## Requirements
- R1: Word address 0 selects the 10-bit working copy, 2 the 10-bit retained copy, 4 the 8-bit working copy and 6 the 8-bit retained copy. A transaction at any other address changes nothing and reads back 8'h00.
- R2: A 10-bit value travels as two bytes. The first byte holds value bits 9:8 in its bits 1:0, and its bits 7:2 are ignored on write and read back as zero. The second byte holds bits 7:0. An 8-bit value travels as one byte. Further bytes in the same transaction are ignored on write and read back as zero.
- R3: A completed write to a working address changes the converter output only at the cycle the end strobe is taken, and leaves the retained copy untouched.
- R4: Reading a working address leaves the converter output unchanged.
- R5: The first read in a transaction on a retained address loads the working copy from the retained copy on that same cycle, and the byte returned comes from that value.
- R6: A completed write to a retained address updates the working copy at the end strobe and, once the commit cycle is over, the retained copy holds that value.
- R7: busy_o rises on the cycle after the end strobe of a retained write and stays high for exactly WR_CYCLES cycles.
- R8: Any strobe taken while busy_o is high produces a one-cycle notrdy_o pulse on the next cycle and has no other effect.
- R9: While rst is high, the 10-bit working copy loads its retained copy if cfg_i[2] is 1, or zero if it is 0, and cfg_i[1] makes the same choice for the 8-bit working copy. Retained copies keep their contents across rst.
- R10: A 10-bit write transaction that ends after only its first byte changes neither 10-bit copy and starts no commit.
- R11: Each read strobe taken when not busy yields rvalid_o high for one cycle on the next cycle, with the byte on rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cfg_i | input | 8 | Configuration byte; bit 2 and bit 1 pick the power-up source |
| sel_i | input | 1 | Open a transaction at addr_i |
| addr_i | input | 8 | Word address |
| wr_i | input | 1 | Write strobe for wdata_i |
| wdata_i | input | 8 | Write byte |
| rd_i | input | 1 | Read strobe |
| end_i | input | 1 | Close the transaction |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | rdata_o valid |
| busy_o | output | 1 | Commit to a retained copy in progress |
| notrdy_o | output | 1 | Strobe refused while busy |
| dac_main_o | output | 10 | 10-bit working copy to its converter |
| dac_aux_o | output | 8 | 8-bit working copy to its converter |

## Verification
The working copies sit directly on dac_main_o and dac_aux_o, so a wrong staging or copy event shows on the converter port one cycle after the strobe that caused it. A retained copy has no port of its own. A bad commit or a reset that clobbers it shows up only on a later retained read or a later power-up load, which can be many transactions after the fault. The bench therefore reads every retained copy back after each commit and after each reset, and counts the busy window cycle by cycle so that an off-by-one in the commit timer shows at the first write.

// File: rtl/dacsh_pkg.sv
package dacsh_pkg;

    localparam logic [7:0] ADDR_MAIN_VOL = 8'd0;
    localparam logic [7:0] ADDR_MAIN_RET = 8'd2;
    localparam logic [7:0] ADDR_AUX_VOL  = 8'd4;
    localparam logic [7:0] ADDR_AUX_RET  = 8'd6;

    typedef struct packed {
        logic ok;       // address maps to a register
        logic is_main;  // 10-bit setting
        logic is_ret;   // retained copy
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [7:0] a);
        addr_dec_t d;
        d.ok      = (a == ADDR_MAIN_VOL) || (a == ADDR_MAIN_RET) ||
                    (a == ADDR_AUX_VOL)  || (a == ADDR_AUX_RET);
        d.is_main = (a == ADDR_MAIN_VOL) || (a == ADDR_MAIN_RET);
        d.is_ret  = (a == ADDR_MAIN_RET) || (a == ADDR_AUX_RET);
        return d;
    endfunction

endpackage

// File: rtl/dacsh_chan.sv
module dacsh_chan #(
    parameter int          W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_from_ret_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         copy_i,
    input  logic         arm_i,
    input  logic         done_i,
    output logic [W-1:0] vol_o,
    output logic [W-1:0] ret_o
);
    logic [W-1:0] vol_q;
    logic [W-1:0] ret_q = INIT;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vol_q  <= pwr_from_ret_i ? ret_q : '0;
            pend_q <= 1'b0;
        end else begin
            if (copy_i)
                vol_q <= ret_q;
            else if (load_i)
                vol_q <= load_val_i;
            if (arm_i)
                pend_q <= 1'b1;
            else if (done_i)
                pend_q <= 1'b0;
        end
    end

    // Retained copy: no reset, updated only at the end of a commit cycle
    always_ff @(posedge clk) begin
        if (!rst && done_i && pend_q)
            ret_q <= vol_q;
    end

    assign vol_o = vol_q;
    assign ret_o = ret_q;
endmodule

// File: rtl/dacsh_wtimer.sv
module dacsh_wtimer #(
    parameter int CYC = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CYC - 1);
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/dac_shadow_regs.sv
module dac_shadow_regs
    import dacsh_pkg::*;
#(
    parameter int               MAIN_W    = 10,
    parameter int               AUX_W     = 8,
    parameter int               WR_CYCLES = 250000,
    parameter logic [MAIN_W-1:0] MAIN_INIT = '0,
    parameter logic [AUX_W-1:0]  AUX_INIT  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cfg_i,
    input  logic              sel_i,
    input  logic [7:0]        addr_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    input  logic              rd_i,
    input  logic              end_i,
    output logic [7:0]        rdata_o,
    output logic              rvalid_o,
    output logic              busy_o,
    output logic              notrdy_o,
    output logic [MAIN_W-1:0] dac_main_o,
    output logic [AUX_W-1:0]  dac_aux_o
);
    localparam int HI_W = MAIN_W - 8;   // bits carried by the first byte

    logic unused_cfg;
    assign unused_cfg = ^{cfg_i[7:3], cfg_i[0]};

    addr_dec_t         dec;
    logic              active_q, is_main_q, is_ret_q, copied_q;
    logic [1:0]        wcnt_q, rcnt_q;
    logic [MAIN_W-1:0] stage_q;
    logic [7:0]        rbyte;
    logic              busy, done, complete;
    logic              do_sel, do_wr, do_rd, do_end, any_req;
    logic              copy_main, copy_aux, load_main, load_aux, arm_main, arm_aux, start_wr;
    logic [MAIN_W-1:0] vol_main, ret_main, src_main;
    logic [AUX_W-1:0]  vol_aux, ret_aux, src_aux;

    assign dec     = decode_addr(addr_i);
    assign any_req = sel_i || wr_i || rd_i || end_i;
    assign do_sel  = !busy && sel_i;
    assign do_wr   = !busy && !sel_i && wr_i;
    assign do_rd   = !busy && !sel_i && !wr_i && rd_i;
    assign do_end  = !busy && !sel_i && !wr_i && !rd_i && end_i;

    assign complete  = is_main_q ? (wcnt_q == 2'd2) : (wcnt_q != 2'd0);
    assign copy_main = do_rd && active_q && is_ret_q && !copied_q && is_main_q;
    assign copy_aux  = do_rd && active_q && is_ret_q && !copied_q && !is_main_q;
    assign load_main = do_end && active_q && complete && is_main_q;
    assign load_aux  = do_end && active_q && complete && !is_main_q;
    assign arm_main  = load_main && is_ret_q;
    assign arm_aux   = load_aux && is_ret_q;
    assign start_wr  = arm_main || arm_aux;

    assign src_main = (is_ret_q && !copied_q) ? ret_main : vol_main;
    assign src_aux  = (is_ret_q && !copied_q) ? ret_aux  : vol_aux;

    always_comb begin
        rbyte = 8'h00;
        if (active_q) begin
            if (is_main_q) begin
                if (rcnt_q == 2'd0)      rbyte = 8'(src_main[MAIN_W-1:8]);
                else if (rcnt_q == 2'd1) rbyte = src_main[7:0];
            end else if (rcnt_q == 2'd0) begin
                rbyte = 8'(src_aux);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            is_main_q <= 1'b0;
            is_ret_q  <= 1'b0;
            copied_q  <= 1'b0;
            wcnt_q    <= '0;
            rcnt_q    <= '0;
            stage_q   <= '0;
            rdata_o   <= '0;
            rvalid_o  <= 1'b0;
            notrdy_o  <= 1'b0;
        end else begin
            rvalid_o <= 1'b0;
            notrdy_o <= busy && any_req;
            if (do_sel) begin
                active_q  <= dec.ok;
                is_main_q <= dec.is_main;
                is_ret_q  <= dec.is_ret;
                copied_q  <= 1'b0;
                wcnt_q    <= '0;
                rcnt_q    <= '0;
                stage_q   <= '0;
            end else if (do_wr && active_q) begin
                if (is_main_q) begin
                    if (wcnt_q == 2'd0) begin
                        stage_q[MAIN_W-1:8] <= wdata_i[HI_W-1:0];
                        wcnt_q <= 2'd1;
                    end else if (wcnt_q == 2'd1) begin
                        stage_q[7:0] <= wdata_i;
                        wcnt_q <= 2'd2;
                    end
                end else if (wcnt_q == 2'd0) begin
                    stage_q[AUX_W-1:0] <= wdata_i[AUX_W-1:0];
                    wcnt_q <= 2'd1;
                end
            end else if (do_rd) begin
                rvalid_o <= 1'b1;
                rdata_o  <= rbyte;
                if (copy_main || copy_aux)
                    copied_q <= 1'b1;
                if (rcnt_q != 2'd2)
                    rcnt_q <= rcnt_q + 2'd1;
            end else if (do_end) begin
                active_q <= 1'b0;
            end
        end
    end

    dacsh_chan #(.W(MAIN_W), .INIT(MAIN_INIT)) u_main (
        .clk(clk), .rst(rst), .pwr_from_ret_i(cfg_i[2]),
        .load_i(load_main), .load_val_i(stage_q),
        .copy_i(copy_main), .arm_i(arm_main), .done_i(done),
        .vol_o(vol_main), .ret_o(ret_main)
    );

    dacsh_chan #(.W(AUX_W), .INIT(AUX_INIT)) u_aux (
        .clk(clk), .rst(rst), .pwr_from_ret_i(cfg_i[1]),
        .load_i(load_aux), .load_val_i(stage_q[AUX_W-1:0]),
        .copy_i(copy_aux), .arm_i(arm_aux), .done_i(done),
        .vol_o(vol_aux), .ret_o(ret_aux)
    );

    dacsh_wtimer #(.CYC(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start_i(start_wr),
        .busy_o(busy), .done_o(done)
    );

    assign busy_o     = busy;
    assign dac_main_o = vol_main;
    assign dac_aux_o  = vol_aux;
endmodule

// File: rtl/dacsh_chk.sv
module dacsh_chk #(
    parameter int MAIN_W = 10,
    parameter int AUX_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic              end_i,
    input logic              rvalid_o,
    input logic              busy_o,
    input logic              notrdy_o,
    input logic [MAIN_W-1:0] dac_main_o,
    input logic [AUX_W-1:0]  dac_aux_o
);
    AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (rst)
        busy_o && (sel_i || wr_i || rd_i || end_i) |=> notrdy_o); // R8

    AST_FLAG_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        notrdy_o |-> $past(busy_o)); // R8

    AST_BUSY_HOLDS_DAC: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(dac_main_o) && $stable(dac_aux_o)); // R8

    AST_DAC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !end_i && !rd_i |=> $stable(dac_main_o) && $stable(dac_aux_o)); // R3

    AST_READ_ACK: assert property (@(posedge clk) disable iff (rst)
        rd_i && !busy_o && !sel_i && !wr_i |=> rvalid_o); // R11

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> $past(rd_i)); // R11
endmodule

bind dac_shadow_regs dacsh_chk #(.MAIN_W(MAIN_W), .AUX_W(AUX_W)) u_chk (
    .clk(clk), .rst(rst), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .end_i(end_i), .rvalid_o(rvalid_o), .busy_o(busy_o),
    .notrdy_o(notrdy_o), .dac_main_o(dac_main_o), .dac_aux_o(dac_aux_o)
);

// File: tb/dac_shadow_regs_tb.sv
module dac_shadow_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WRC        = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg = 8'h00;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, en = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       rvalid, busy, notrdy;
    logic [9:0] dac_main;
    logic [7:0] dac_aux;

    int n_run = 0, n_fail = 0, cyc = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    dac_shadow_regs #(.WR_CYCLES(WRC), .MAIN_INIT(10'h2A5), .AUX_INIT(8'h3C)) u_dut (
        .clk(clk), .rst(rst), .cfg_i(cfg), .sel_i(sel), .addr_i(addr),
        .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .end_i(en),
        .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy), .notrdy_o(notrdy),
        .dac_main_o(dac_main), .dac_aux_o(dac_aux)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_dac(input string tag, input int m, input int a);
        check(dac_main == 10'(m), {tag, " main"}, int'(dac_main), m);
        check(dac_aux == 8'(a), {tag, " aux"}, int'(dac_aux), a);
    endtask

    // One strobe for one cycle; returns at the negedge after it was taken
    task automatic strobe(input bit s, input bit w, input bit r, input bit e, input logic [7:0] v);
        @(negedge clk);
        sel = s; wr = w; rd = r; en = e;
        if (s) addr = v;
        if (w) wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; rd = 1'b0; en = 1'b0;
    endtask

    task automatic open_t(input logic [7:0] a);  strobe(1, 0, 0, 0, a); endtask
    task automatic put(input logic [7:0] d);     strobe(0, 1, 0, 0, d); endtask
    task automatic close_t();                    strobe(0, 0, 0, 1, 8'h00); endtask
    task automatic get(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        strobe(0, 0, 1, 0, 8'h00);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic power_up(input logic [7:0] c);
        @(negedge clk);
        cfg = c; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (exp_q.size() == 0) begin
                check(0, "R11 unexpected rvalid", int'(rdata), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rdata == e, t, int'(rdata), int'(e));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int nb;
        power_up(8'h00);
        chk_dac("R9 zero power-up", 0, 0);
        check(!busy, "R7 idle after reset", int'(busy), 0);

        // Working 10-bit write: first byte bits 7:2 ignored
        open_t(8'd0);
        put(8'hFE);
        put(8'h34);
        chk_dac("R3 no change before end", 0, 0);
        close_t();
        chk_dac("R2 R3 main write", 16'h234, 0);
        check(!busy, "R3 working write starts no commit", int'(busy), 0);

        // Working read: format and no effect
        open_t(8'd0);
        get(8'h02, "R2 main high byte");
        get(8'h34, "R2 main low byte");
        get(8'h00, "R2 extra byte reads zero");
        close_t();
        chk_dac("R4 read leaves dac", 16'h234, 0);

        // Working 8-bit write
        open_t(8'd4);
        put(8'h9A);
        put(8'h77);
        close_t();
        chk_dac("R1 aux write", 16'h234, 16'h9A);

        // Retained read copies to working copy at the read
        open_t(8'd2);
        chk_dac("R5 no copy at select", 16'h234, 16'h9A);
        get(8'h02, "R5 retained high byte");
        check(dac_main == 10'h2A5, "R5 dac moves at read", int'(dac_main), 16'h2A5);
        get(8'hA5, "R5 retained low byte");
        close_t();

        // Retained 8-bit write and busy window
        open_t(8'd6);
        put(8'h5B);
        close_t();
        check(dac_aux == 8'h5B, "R6 working copy at end", int'(dac_aux), 16'h5B);
        nb = 0;
        while (busy) begin nb++; @(negedge clk); end
        check(nb == WRC, "R7 busy length", nb, WRC);

        // Working write then retained read: retained copy kept committed value
        open_t(8'd4);
        put(8'h11);
        close_t();
        check(dac_aux == 8'h11, "R3 aux working write", int'(dac_aux), 16'h11);
        open_t(8'd6);
        get(8'h5B, "R6 R3 retained holds commit");
        close_t();
        check(dac_aux == 8'h5B, "R5 aux copy", int'(dac_aux), 16'h5B);

        // Refusal while busy
        open_t(8'd2);
        put(8'h01);
        put(8'hC3);
        close_t();
        check(dac_main == 10'h1C3, "R6 main working at end", int'(dac_main), 16'h1C3);
        open_t(8'd4);
        check(notrdy == 1'b1, "R8 select refused", int'(notrdy), 1);
        put(8'hEE);
        close_t();
        check(notrdy == 1'b1, "R8 end refused", int'(notrdy), 1);
        chk_dac("R8 no effect while busy", 16'h1C3, 16'h5B);
        wait_idle();
        @(negedge clk);
        check(notrdy == 1'b0, "R8 flag clears", int'(notrdy), 0);

        // Incomplete 10-bit writes
        open_t(8'd0);
        put(8'h03);
        close_t();
        check(dac_main == 10'h1C3, "R10 one byte working", int'(dac_main), 16'h1C3);
        open_t(8'd2);
        put(8'h00);
        close_t();
        check(!busy, "R10 one byte retained no commit", int'(busy), 0);
        open_t(8'd2);
        get(8'h01, "R10 R6 retained high");
        get(8'hC3, "R10 R6 retained low");
        close_t();

        // Unmapped address
        open_t(8'd5);
        put(8'hFF);
        get(8'h00, "R1 unmapped reads zero");
        close_t();
        chk_dac("R1 unmapped no effect", 16'h1C3, 16'h5B);

        // Power-up source selection; retained copies survive reset
        open_t(8'd0);
        put(8'h00);
        put(8'h00);
        close_t();
        power_up(8'h06);
        chk_dac("R9 both from retained", 16'h1C3, 16'h5B);
        power_up(8'h04);
        chk_dac("R9 main only", 16'h1C3, 0);
        power_up(8'h02);
        chk_dac("R9 aux only", 0, 16'h5B);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule